// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Sequencer

This block is the command-side control logic inside a single-data-rate SDRAM device. A decoded command arrives every clock. A mode-load command captures the device settings from the address bus. These settings are the burst length, the read latency counted in clocks, and a flag that makes every write a single-location access. Read and write commands then start column bursts that follow those settings. Each burst produces one internal array strobe per cycle, and each strobe carries a column address that wraps inside a block aligned to the burst length.

For reads, a short pipeline delays each array strobe by the programmed latency to produce a data-valid flag. The pipeline also raises an output-enable one cycle before the first valid word. The enable stays high across back-to-back read data. A mode value that selects a reserved or test setting is rejected: the previous settings are kept and an error flag is raised until the next legal mode load.

Top module: `sdram_mode_seq`

## Requirements
- R1: While the reset is asserted and after it is released, every strobe, dq_oe_o, dq_valid_o and mode_err_o are low. The mode in force is burst length 1, latency 2, and writes follow the burst length.
- R2: The command encoding is 0 NOP, 1 mode load, 2 READ and 3 WRITE. On a mode load with a legal value, the new settings apply from the next command onward and mode_err_o goes low in the cycle after the load.
- R3: A mode load with bits [8:7] not equal to 00 sets mode_err_o in the cycle after the load and leaves the previous settings in force.
- R4: The burst-length field is bits [2:0], where 000, 001, 010 and 011 mean 1, 2, 4 and 8. The latency field is bits [6:4], where 010 means 2 and 011 means 3. A mode load with any other code in either field sets mode_err_o and keeps the previous settings. mode_err_o changes only after a mode load.
- R5: A READ sampled at edge n drives rd_stb_o in the cycles that start at edges n through n+BL-1. The first of these cycles carries the column given with the command.
- R6: Word k of a burst uses the column (base with its low log2(BL) bits cleared) OR ((base+k) mod BL).
- R7: For a READ sampled at edge n with latency m, dq_valid_o is high in the cycles that start at edges n+m through n+m+BL-1.
- R8: dq_oe_o is high in the cycle before each valid word and in every cycle in which dq_valid_o is high. It therefore drops one cycle after the last valid word, unless further read data follows directly.
- R9: A WRITE sampled at edge n while bit 9 of the mode is 0 drives wr_stb_o for BL cycles, with columns as in R6.
- R10: While bit 9 of the mode is 1, a WRITE drives wr_stb_o for exactly one cycle, and READ bursts keep the programmed length.
- R11: A READ or WRITE that arrives during a burst ends that burst at once and starts the new one. Read words already in the latency pipeline still come out valid, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_i | input | 2 | Decoded command: 0 NOP, 1 mode load, 2 READ, 3 WRITE |
| mode_i | input | ADDR_W | Address bus; it carries the mode value on a mode load |
| col_i | input | COL_W | Start column for READ and WRITE |
| rd_stb_o | output | 1 | Array read strobe, one per burst word |
| rd_col_o | output | COL_W | Column for the array read |
| wr_stb_o | output | 1 | Array write strobe, one per burst word |
| wr_col_o | output | COL_W | Column for the array write |
| dq_oe_o | output | 1 | Data-output enable |
| dq_valid_o | output | 1 | Read data word valid |
| mode_err_o | output | 1 | The last mode load used a reserved or test encoding |

## Verification
The bench builds the block with its default widths: a 12-bit address bus and a 9-bit column. Starting columns near the top of the column range therefore show wrapping inside the aligned block rather than carry into higher bits. Directed sequences cover every legal burst length under both latencies, back-to-back reads that keep the output enabled, truncation by both command types, and the single-write flag. A seeded random run mixes mode loads (some reserved) with overlapping reads and writes, so latency changes and truncations occur while the pipeline is busy.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_SETMODE = 2'd1,
    CMD_READ    = 2'd2,
    CMD_WRITE   = 2'd3
  } cmd_e;

  // field positions inside the mode value
  localparam int BL_LSB = 0;
  localparam int CL_LSB = 4;
  localparam int OP_LSB = 7;
  localparam int WS_BIT = 9;

  // largest burst is 8 words, largest latency is 3 clocks
  localparam int LEN_W   = 4;
  localparam int IDX_W   = 3;
  localparam int MAX_LAT = 3;

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] mode_i,
  output logic [LEN_W-1:0]  bl_len_o,
  output logic              cl3_o,
  output logic              wsingle_o,
  output logic              err_o
);

  logic [1:0] bl_code_q, bl_code_d;
  logic       cl3_q, cl3_d;
  logic       ws_q, ws_d;
  logic       err_q, err_d;

  logic [2:0] bl_field;
  logic [2:0] cl_field;
  logic [1:0] op_field;
  logic       legal;
  logic       unused_mode_bits;

  assign bl_field = mode_i[BL_LSB +: 3];
  assign cl_field = mode_i[CL_LSB +: 3];
  assign op_field = mode_i[OP_LSB +: 2];
  assign unused_mode_bits = ^{mode_i[3], mode_i[ADDR_W-1:WS_BIT+1]};

  always_comb begin
    legal = (op_field == 2'b00) &&
            (cl_field == 3'b010 || cl_field == 3'b011) &&
            (bl_field[2] == 1'b0);

    bl_code_d = bl_code_q;
    cl3_d     = cl3_q;
    ws_d      = ws_q;
    err_d     = err_q;

    if (load_i) begin
      err_d = !legal;
      if (legal) begin
        bl_code_d = bl_field[1:0];
        cl3_d     = cl_field[0];
        ws_d      = mode_i[WS_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_code_q <= 2'b00;
      cl3_q     <= 1'b0;
      ws_q      <= 1'b0;
      err_q     <= 1'b0;
    end else if (load_i) begin
      bl_code_q <= bl_code_d;
      cl3_q     <= cl3_d;
      ws_q      <= ws_d;
      err_q     <= err_d;
    end
  end

  assign bl_len_o  = LEN_W'(1) << bl_code_q;
  assign cl3_o     = cl3_q;
  assign wsingle_o = ws_q;
  assign err_o     = err_q;

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             start_rd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] start_len_i,
  output logic             rd_stb_o,
  output logic             wr_stb_o,
  output logic [COL_W-1:0] col_o
);

  logic             act_q, act_d;
  logic             isrd_q, isrd_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             last_word;
  logic             adv_en;

  assign last_word = ({1'b0, idx_q} == (len_q - LEN_W'(1)));
  assign adv_en    = start_i || act_q;

  always_comb begin
    act_d  = act_q;
    isrd_d = isrd_q;
    base_d = base_q;
    idx_d  = idx_q;
    len_d  = len_q;
    if (start_i) begin
      act_d  = 1'b1;
      isrd_d = start_rd_i;
      base_d = start_col_i;
      idx_d  = '0;
      len_d  = start_len_i;
    end else if (act_q) begin
      if (last_word) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      isrd_q <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      len_q  <= LEN_W'(1);
    end else if (adv_en) begin
      act_q  <= act_d;
      isrd_q <= isrd_d;
      base_q <= base_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
    end
  end

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum_col;

  assign wrap_mask = {{(COL_W-LEN_W){1'b0}}, len_q - LEN_W'(1)};
  assign sum_col   = base_q + {{(COL_W-IDX_W){1'b0}}, idx_q};
  assign col_o     = (base_q & ~wrap_mask) | (sum_col & wrap_mask);
  assign rd_stb_o  = act_q && isrd_q;
  assign wr_stb_o  = act_q && !isrd_q;

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic cl3_i,
  output logic valid_o,
  output logic oe_o
);

  logic [DEPTH-1:0] pipe_q, pipe_d;

  assign pipe_d[0] = stb_i;

  genvar gi;
  generate
    for (gi = 1; gi < DEPTH; gi++) begin : g_stage
      assign pipe_d[gi] = pipe_q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  // stage k holds a strobe delayed by k+1 clocks
  logic valid_now;
  logic valid_next;

  always_comb begin
    if (cl3_i) begin
      valid_now  = pipe_q[DEPTH-1];
      valid_next = pipe_q[DEPTH-2];
    end else begin
      valid_now  = pipe_q[DEPTH-2];
      valid_next = pipe_q[DEPTH-3];
    end
  end

  assign valid_o = valid_now;
  assign oe_o    = valid_now || valid_next;

endmodule

// File: rtl/sdram_mode_seq.sv
module sdram_mode_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] mode_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              rd_stb_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic              wr_stb_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic              dq_oe_o,
  output logic              dq_valid_o,
  output logic              mode_err_o
);

  localparam int PIPE_D = MAX_LAT;

  logic             rst_s;
  cmd_e             cmd;
  logic [LEN_W-1:0] bl_len;
  logic             cl3;
  logic             wsingle;
  logic             start;
  logic             start_rd;
  logic [LEN_W-1:0] start_len;
  logic [COL_W-1:0] burst_col;

  assign cmd = cmd_e'(cmd_i);

  sdram_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s)
  );

  sdram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_s),
    .load_i    (cmd == CMD_SETMODE),
    .mode_i    (mode_i),
    .bl_len_o  (bl_len),
    .cl3_o     (cl3),
    .wsingle_o (wsingle),
    .err_o     (mode_err_o)
  );

  assign start     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign start_rd  = (cmd == CMD_READ);
  assign start_len = (!start_rd && wsingle) ? LEN_W'(1) : bl_len;

  sdram_burst_gen #(.COL_W(COL_W)) u_burst (
    .clk         (clk),
    .rst_n       (rst_s),
    .start_i     (start),
    .start_rd_i  (start_rd),
    .start_col_i (col_i),
    .start_len_i (start_len),
    .rd_stb_o    (rd_stb_o),
    .wr_stb_o    (wr_stb_o),
    .col_o       (burst_col)
  );

  assign rd_col_o = burst_col;
  assign wr_col_o = burst_col;

  sdram_rd_pipe #(.DEPTH(PIPE_D)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_s),
    .stb_i   (rd_stb_o),
    .cl3_i   (cl3),
    .valid_o (dq_valid_o),
    .oe_o    (dq_oe_o)
  );

endmodule

// File: rtl/sdram_mode_seq_chk.sv
module sdram_mode_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_i,
  input logic [COL_W-1:0] col_i,
  input logic             rd_stb_o,
  input logic [COL_W-1:0] rd_col_o,
  input logic             wr_stb_o,
  input logic             dq_oe_o,
  input logic             dq_valid_o,
  input logic             mode_err_o
);

  // R5
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) == 2'd2) |-> (rd_stb_o && rd_col_o == $past(col_i)));

  // R9
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) == 2'd3) |-> (wr_stb_o && !rd_stb_o));

  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o && $past(rd_stb_o) && $past(cmd_i) != 2'd2 && $past(cmd_i) != 2'd3)
      |-> (rd_col_o[0] != $past(rd_col_o[0])));

  // R8
  valid_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid_o |-> dq_oe_o);

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) != 2'd1) |-> $stable(mode_err_o));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb_o, wr_stb_o}));

endmodule

bind sdram_mode_seq sdram_mode_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .cmd_i      (cmd_i),
  .col_i      (col_i),
  .rd_stb_o   (rd_stb_o),
  .rd_col_o   (rd_col_o),
  .wr_stb_o   (wr_stb_o),
  .dq_oe_o    (dq_oe_o),
  .dq_valid_o (dq_valid_o),
  .mode_err_o (mode_err_o)
);

// File: tb/sdram_mode_seq_tb.sv
module sdram_mode_seq_tb;

  localparam int ADDR_W = 12;
  localparam int COL_W  = 9;

  logic              clk;
  logic              rst_n;
  logic [1:0]        cmd_i;
  logic [ADDR_W-1:0] mode_i;
  logic [COL_W-1:0]  col_i;
  logic              rd_stb_o;
  logic [COL_W-1:0]  rd_col_o;
  logic              wr_stb_o;
  logic [COL_W-1:0]  wr_col_o;
  logic              dq_oe_o;
  logic              dq_valid_o;
  logic              mode_err_o;

  sdram_mode_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .mode_i(mode_i), .col_i(col_i),
    .rd_stb_o(rd_stb_o), .rd_col_o(rd_col_o), .wr_stb_o(wr_stb_o),
    .wr_col_o(wr_col_o), .dq_oe_o(dq_oe_o), .dq_valid_o(dq_valid_o),
    .mode_err_o(mode_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  bit rd_slot [64];
  int rd_cs   [64];
  bit wr_slot [64];
  int wr_cs   [64];
  int cyc = 0;
  int mbl = 1;
  int mcl = 2;
  bit mws = 0;
  bit merr = 0;

  function automatic bit legal_mode(logic [ADDR_W-1:0] m);
    return (m[8:7] == 2'b00) && (m[6:4] == 3'd2 || m[6:4] == 3'd3) && !m[2];
  endfunction

  function automatic int wrap_col(int base, int k, int len);
    return ((base & ~(len - 1)) | ((base + k) & (len - 1))) & 'h1FF;
  endfunction

  task automatic fail_msg(string req, int act, int exp);
    fails++;
    $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
  endtask

  task automatic check_cycle();
    bit e_rd, e_wr, e_val, e_oe;
    int okc;
    e_rd  = rd_slot[cyc & 63];
    e_wr  = wr_slot[cyc & 63];
    e_val = rd_slot[(cyc - mcl) & 63];
    e_oe  = e_val | rd_slot[(cyc - mcl + 1) & 63];
    okc   = fails;
    tests++;
    if (rd_stb_o !== e_rd) fail_msg("R5 rd_stb", rd_stb_o, e_rd);
    else if (e_rd && rd_col_o !== COL_W'(rd_cs[cyc & 63]))
      fail_msg("R6 rd_col", rd_col_o, rd_cs[cyc & 63]);
    if (wr_stb_o !== e_wr) fail_msg("R9 R10 wr_stb", wr_stb_o, e_wr);
    else if (e_wr && wr_col_o !== COL_W'(wr_cs[cyc & 63]))
      fail_msg("R9 wr_col", wr_col_o, wr_cs[cyc & 63]);
    if (dq_valid_o !== e_val) fail_msg("R7 dq_valid", dq_valid_o, e_val);
    if (dq_oe_o !== e_oe) fail_msg("R8 dq_oe", dq_oe_o, e_oe);
    if (mode_err_o !== merr) fail_msg("R3 R4 mode_err", mode_err_o, merr);
    if (fails != okc && fails > okc + 3) fails = okc + 1;
  endtask

  task automatic apply(int cmd, logic [ADDR_W-1:0] m, int col);
    int len;
    rd_slot[(cyc + 8) & 63] = 0;
    wr_slot[(cyc + 8) & 63] = 0;
    if (cmd == 1) begin
      if (legal_mode(m)) begin
        mbl = 1 << m[1:0];
        mcl = int'(m[6:4]);
        mws = m[9];
        merr = 0;
      end else begin
        merr = 1;
      end
    end else if (cmd >= 2) begin
      len = (cmd == 3 && mws) ? 1 : mbl;
      for (int k = 0; k < 8; k++) begin
        rd_slot[(cyc + k) & 63] = 0;
        wr_slot[(cyc + k) & 63] = 0;
      end
      for (int k = 0; k < len; k++) begin
        if (cmd == 2) begin
          rd_slot[(cyc + k) & 63] = 1;
          rd_cs[(cyc + k) & 63]   = wrap_col(col, k, len);
        end else begin
          wr_slot[(cyc + k) & 63] = 1;
          wr_cs[(cyc + k) & 63]   = wrap_col(col, k, len);
        end
      end
    end
  endtask

  task automatic step(int cmd, int m, int col);
    @(negedge clk);
    check_cycle();
    cmd_i  = 2'(cmd);
    mode_i = ADDR_W'(m);
    col_i  = COL_W'(col);
    @(posedge clk);
    cyc++;
    apply(cmd, ADDR_W'(m), col);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      rd_slot[i] = 0; wr_slot[i] = 0; rd_cs[i] = 0; wr_cs[i] = 0;
    end
    rst_n = 1'b0;
    cmd_i = 2'd0; mode_i = '0; col_i = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 outputs quiet during reset
    tests++;
    if ({rd_stb_o, wr_stb_o, dq_oe_o, dq_valid_o, mode_err_o} !== 5'b0)
      fail_msg("R1 reset outputs",
               {rd_stb_o, wr_stb_o, dq_oe_o, dq_valid_o, mode_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 default mode: single read, latency 2
    step(2, 0, 5); idle(5);
    // R2 burst 4 latency 2, wrap R6: 6,7,4,5
    step(1, 'h022, 0); step(2, 0, 6); idle(7);
    // burst 8 latency 3 near column top
    step(1, 'h033, 0); step(2, 0, 'h1FD); idle(7);
    // R8 back-to-back reads keep oe high
    step(2, 0, 'h10); idle(7); step(2, 0, 'h20); idle(10);
    // R11 truncation by read then by write
    step(2, 0, 'h40); idle(2); step(2, 0, 'h53); idle(10);
    step(2, 0, 'h60); step(0, 0, 0); step(3, 0, 'h71); idle(10);
    // burst 2 latency 2
    step(1, 'h021, 0); step(2, 0, 'h0F); step(3, 0, 'h0F); idle(6);
    // R10 single writes, reads keep length
    step(1, 'h233, 0); step(3, 0, 'h12); idle(3); step(2, 0, 'h12); idle(12);
    // R9 write burst 4
    step(1, 'h022, 0); step(3, 0, 'h1FE); idle(6);
    // R3 reserved op bits, R4 reserved latency and length codes
    step(1, 'h0A2, 0); idle(1); step(2, 0, 'h30); idle(6);
    step(1, 'h132, 0); idle(1);
    step(1, 'h012, 0); idle(1);
    step(1, 'h026, 0); step(2, 0, 'h35); idle(6);
    step(1, 'h033, 0); idle(2);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      int r, c, m;
      r = int'($urandom_range(0, 99));
      c = int'($urandom_range(0, 511));
      if ($urandom_range(0, 4) == 0) m = int'($urandom_range(0, 4095));
      else m = int'($urandom_range(0, 1)) << 9 | int'($urandom_range(2, 3)) << 4
             | int'($urandom_range(0, 3));
      if (r < 50) step(0, 0, 0);
      else if (r < 70) step(2, 0, c);
      else if (r < 90) step(3, 0, c);
      else step(1, m, 0);
    end
    idle(12);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule